// File: doc/BRIEF.md
# Bus-Matching Width Converter with Endian Select

This block sits in front of or behind a queue and lets the writing side and the reading side use different bus widths. The internal word is four lanes of `LANE_W` bits (36 bits by default). A configuration code picks one of five width pairings: wide to wide, wide to half, wide to quarter, half to wide and quarter to wide. A byte-order select decides whether the most or the least significant part of a wide word travels first on the narrow side. Both controls are captured only while reset is held, and they keep their value until the next reset.

A wide input word is either forwarded whole or split into two or four parts that leave in consecutive output beats. Narrow input parts are instead packed into a holding register, and the full word is released once its last part has arrived. Both sides use a valid/ready handshake. A stalled output freezes the part counter and blocks new input, so no data is lost.

The control is a three-state machine. `ST_EMPTY` means the holding register has nothing in it. `ST_FILL` means a packed word is partly collected. `ST_DRAIN` means the register drives the output. The named transitions are:

- `load` (EMPTY→DRAIN): a wide word is accepted.
- `begin_pack` (EMPTY→FILL): a first narrow part is accepted.
- `complete` (FILL→DRAIN): the last narrow part is accepted.
- `next_part` (DRAIN→DRAIN): an emitted part was not the last one.
- `reload` (DRAIN→DRAIN or DRAIN→FILL): the last beat leaves while new input is taken in the same cycle.
- `release` (DRAIN→EMPTY): the last beat leaves and no new input is taken.

Top module: `bus_width_conv`

## Requirements
- R1: `cfg_mode` and `cfg_big` are captured on every clock edge while `rst_n` is low and are ignored afterwards. A change after reset does not alter the behaviour.
- R2: Mode codes are 0 = wide→wide, 1 = wide→half, 2 = wide→quarter, 3 = half→wide, 4 = quarter→wide. Codes 5 to 7 behave as code 0.
- R3: In modes 1 and 2, each accepted wide word produces 2 or 4 output beats. Each beat carries its part in the low bits of `out_data`, and all bits above the part width are zero.
- R4: With `cfg_big`=1 the most significant part goes first on the narrow side, whether splitting or packing. With `cfg_big`=0 the least significant part goes first.
- R5: In modes 3 and 4 the packed wide word appears on the output only after all 2 or 4 parts have been accepted. Only the low half or low quarter of `in_data` is used, and the upper input bits have no effect.
- R6: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` hold their values and `in_ready` is 0. No word or part is lost or duplicated.
- R7: After reset `out_valid`=0 and `in_ready`=1, and any partly packed word is discarded.
- R8: In mode 0 with `out_ready` held high, `in_ready` stays high, so one word passes per cycle.
- R9: A word accepted at a clock edge is presented on `out_valid`/`out_data` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; configuration is captured while low |
| cfg_mode | input | 3 | Width pairing code (see R2) |
| cfg_big | input | 1 | 1: most significant part first on the narrow side |
| in_data | input | 4*LANE_W | Input word; narrow modes use the low bits |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word taken when high together with in_valid |
| out_data | output | 4*LANE_W | Output word or part (low bits) |
| out_valid | output | 1 | Output word or part offered |
| out_ready | input | 1 | Downstream takes the output |

## Verification
The bench builds the block with the default `LANE_W` of 9, which gives the 36/18/9-bit widths. Every pairing, including one illegal code, is reachable in both byte orders within a few hundred cycles. Random valid and ready patterns produce stalls on the last part, same-cycle reloads and mid-pack idles. Directed cases cover the configuration pins changing after reset, a reset in the middle of packing, and the one-word-per-cycle pass-through.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    localparam int LANES     = 4;
    localparam int LOG_LANES = 2;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FILL  = 2'd1,
        ST_DRAIN = 2'd2
    } fsm_e;

    typedef struct packed {
        logic                 pack;
        logic                 big;
        logic [LOG_LANES-1:0] in_log;
        logic [LOG_LANES-1:0] out_log;
    } cfg_t;

    function automatic cfg_t decode_cfg(input logic [2:0] code, input logic big);
        cfg_t c;
        c.pack    = 1'b0;
        c.big     = big;
        c.in_log  = LOG_LANES'(2);
        c.out_log = LOG_LANES'(2);
        case (code)
            3'd1: c.out_log = LOG_LANES'(1);
            3'd2: c.out_log = LOG_LANES'(0);
            3'd3: begin c.in_log = LOG_LANES'(1); c.pack = 1'b1; end
            3'd4: begin c.in_log = LOG_LANES'(0); c.pack = 1'b1; end
            default: c.pack = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bwc_cfg_latch.sv
module bwc_cfg_latch
    import bwc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_pin,
    input  logic       big_pin,
    output cfg_t       cfg
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= decode_cfg(mode_pin, big_pin);
        end
    end

endmodule

// File: rtl/bwc_lane_merge.sv
module bwc_lane_merge
    import bwc_pkg::*;
#(
    parameter int LANE_W = 9
) (
    input  logic [LANE_W-1:0]    in_l    [LANES],
    input  logic [LOG_LANES-1:0] slot,
    input  logic [LOG_LANES-1:0] pl_log,
    input  logic                 load,
    output logic [LANES-1:0]     wr_en,
    output logic [LANE_W-1:0]    wr_lane [LANES]
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LOG_LANES-1:0] owner;
        logic [LOG_LANES-1:0] src;
        assign owner      = LOG_LANES'(k) >> pl_log;
        assign src        = LOG_LANES'(k) - (slot << pl_log);
        assign wr_en[k]   = load && (owner == slot);
        assign wr_lane[k] = in_l[src];
    end

endmodule

// File: rtl/bwc_lane_sel.sv
module bwc_lane_sel
    import bwc_pkg::*;
#(
    parameter int LANE_W = 9
) (
    input  logic [LANE_W-1:0]    hold_l [LANES],
    input  logic [LOG_LANES-1:0] slice,
    input  logic [LOG_LANES-1:0] pl_log,
    output logic [LANE_W-1:0]    out_l  [LANES]
);

    localparam int LCNT_W = LOG_LANES + 1;

    logic [LCNT_W-1:0] part_lanes;
    assign part_lanes = LCNT_W'(1) << pl_log;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [LOG_LANES-1:0] src;
        assign src      = (slice << pl_log) + LOG_LANES'(j);
        assign out_l[j] = (LCNT_W'(j) < part_lanes) ? hold_l[src] : '0;
    end

endmodule

// File: rtl/bus_width_conv.sv
module bus_width_conv
    import bwc_pkg::*;
#(
    parameter  int LANE_W = 9,
    localparam int WIDE_W = LANE_W * bwc_pkg::LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_big,
    input  logic [WIDE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [WIDE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);

    localparam int LIDX_W = LOG_LANES;
    localparam int LCNT_W = LOG_LANES + 1;

    cfg_t               cfg;
    fsm_e               state_q, state_d;
    logic [LIDX_W-1:0]  cnt_q, cnt_d;
    logic [LANE_W-1:0]  in_l    [LANES];
    logic [LANE_W-1:0]  hold_l  [LANES];
    logic [LANE_W-1:0]  wr_lane [LANES];
    logic [LANE_W-1:0]  out_l   [LANES];
    logic [LANES-1:0]   wr_en;
    logic [LIDX_W-1:0]  parts_log, cnt_max, arr_idx, in_slot, out_slot;
    logic               last_beat, accept, emit;

    bwc_cfg_latch u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_pin (cfg_mode),
        .big_pin  (cfg_big),
        .cfg      (cfg)
    );

    // derived per-configuration counts
    assign parts_log = LIDX_W'(LOG_LANES) - (cfg.pack ? cfg.in_log : cfg.out_log);
    assign cnt_max   = LIDX_W'((LCNT_W'(1) << parts_log) - LCNT_W'(1));

    for (genvar k = 0; k < LANES; k++) begin : g_io
        assign in_l[k] = in_data[k*LANE_W +: LANE_W];
        assign out_data[k*LANE_W +: LANE_W] = out_l[k];
    end

    // output process
    always_comb begin
        out_valid = (state_q == ST_DRAIN);
        last_beat = cfg.pack || (cnt_q == cnt_max);
        in_ready  = (state_q != ST_DRAIN) || (out_ready && last_beat);
        accept    = in_valid && in_ready;
        emit      = out_valid && out_ready;
        arr_idx   = (state_q == ST_FILL) ? cnt_q : '0;
        in_slot   = !cfg.pack ? '0 : (cfg.big ? cnt_max - arr_idx : arr_idx);
        out_slot  = cfg.pack ? '0 : (cfg.big ? cnt_max - cnt_q : cnt_q);
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (accept) begin            // load / begin_pack
                    state_d = cfg.pack ? ST_FILL : ST_DRAIN;
                    cnt_d   = cfg.pack ? LIDX_W'(1) : '0;
                end
            end
            ST_FILL: begin
                if (accept) begin
                    if (cnt_q == cnt_max) begin   // complete
                        state_d = ST_DRAIN;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                if (emit) begin
                    if (!last_beat) begin         // next_part
                        cnt_d = cnt_q + 1'b1;
                    end else if (accept) begin    // reload
                        state_d = cfg.pack ? ST_FILL : ST_DRAIN;
                        cnt_d   = cfg.pack ? LIDX_W'(1) : '0;
                    end else begin                // release
                        state_d = ST_EMPTY;
                        cnt_d   = '0;
                    end
                end
            end
            default: begin
                state_d = ST_EMPTY;
                cnt_d   = '0;
            end
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    bwc_lane_merge #(.LANE_W(LANE_W)) u_merge (
        .in_l    (in_l),
        .slot    (in_slot),
        .pl_log  (cfg.in_log),
        .load    (accept),
        .wr_en   (wr_en),
        .wr_lane (wr_lane)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_hold
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_l[k] <= '0;
            end else if (wr_en[k]) begin
                hold_l[k] <= wr_lane[k];
            end
        end
    end

    bwc_lane_sel #(.LANE_W(LANE_W)) u_sel (
        .hold_l (hold_l),
        .slice  (out_slot),
        .pl_log (cfg.out_log),
        .out_l  (out_l)
    );

    // R1
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg));

    // R3
    narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (cfg.out_log != LIDX_W'(LOG_LANES)) |->
            ((out_data >> (LANE_W << cfg.out_log)) == '0));

    // R3
    part_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= cnt_max);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R6
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R7
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid && in_ready);

endmodule

// File: tb/sim_bus_width_conv.sv
module sim_bus_width_conv;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_mode = 3'd0;
    logic        cfg_big = 1'b0;
    logic [35:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [35:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int          eff_mode;
    bit          eff_big;
    logic [35:0] exp_q[$];
    logic [35:0] acc;
    int          acc_n;
    bit          prev_stall;
    logic [35:0] prev_data;
    int          beats;
    logic [35:0] last_out;

    bus_width_conv u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_big(cfg_big),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] lmask(input int nl);
        return (nl >= 4) ? 36'hF_FFFF_FFFF : ((36'd1 << (nl*9)) - 36'd1);
    endfunction

    function automatic int lanes_in(input int m);
        return (m == 3) ? 2 : (m == 4) ? 1 : 4;
    endfunction

    function automatic int lanes_out(input int m);
        return (m == 1) ? 2 : (m == 2) ? 1 : 4;
    endfunction

    task automatic model_in(input logic [35:0] w);
        int ni = lanes_in(eff_mode);
        int no = lanes_out(eff_mode);
        int n, s;
        if (eff_mode <= 2) begin
            n = ni / no;
            for (int i = 0; i < n; i++) begin
                s = eff_big ? n - 1 - i : i;
                exp_q.push_back((w >> (s*no*9)) & lmask(no));
            end
        end else begin
            n = no / ni;
            s = eff_big ? n - 1 - acc_n : acc_n;
            acc = acc | ((w & lmask(ni)) << (s*ni*9));
            acc_n++;
            if (acc_n == n) begin
                exp_q.push_back(acc);
                acc = '0;
                acc_n = 0;
            end
        end
    endtask

    task automatic step(input bit iv, input logic [35:0] d, input bit ordy);
        logic [35:0] e;
        @(negedge clk);
        in_valid = iv; in_data = d; out_ready = ordy;
        #1;
        if (out_valid && prev_stall)
            chk(out_data == prev_data, "R6 stalled data", out_data, prev_data);
        if (prev_stall)
            chk(out_valid == 1'b1, "R6 stalled valid", {35'd0, out_valid}, 36'd1);
        if (out_valid && !out_ready)
            chk(in_ready == 1'b0, "R6 input blocked", {35'd0, in_ready}, 36'd0);
        if (out_valid && out_ready) begin
            beats++;
            last_out = out_data;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3/R5 unexpected beat", out_data, 36'd0);
            end else begin
                e = exp_q.pop_front();
                chk(out_data == e, "R2/R3/R4/R5 beat", out_data, e);
            end
        end
        if (in_valid && in_ready) model_in(in_data);
        prev_stall = out_valid && !out_ready;
        prev_data = out_data;
    endtask

    task automatic do_reset(input int m, input bit big);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        cfg_mode = 3'(m); cfg_big = big;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        eff_mode = (m > 4) ? 0 : m;
        eff_big = big;
        exp_q.delete(); acc = '0; acc_n = 0; prev_stall = 0; beats = 0;
        #1;
        chk(out_valid == 1'b0, "R7 out_valid after reset", {35'd0, out_valid}, 36'd0);
        chk(in_ready == 1'b1, "R7 in_ready after reset", {35'd0, in_ready}, 36'd1);
    endtask

    task automatic drain();
        for (int i = 0; i < 10; i++) step(1'b0, '0, 1'b1);
        chk(exp_q.size() == 0, "R3/R5 all parts delivered", 36'(exp_q.size()), 36'd0);
    endtask

    initial begin
        logic [35:0] w;
        void'($urandom(32'd20240611));

        // R1: pins change after reset, latched mode stays
        do_reset(2, 1'b1);
        cfg_mode = 3'd0; cfg_big = 1'b0;
        step(1'b1, 36'h1_2345_6789, 1'b1);
        for (int i = 0; i < 6; i++) step(1'b0, '0, 1'b1);
        chk(beats == 4, "R1 beats after pin change", 36'(beats), 36'd4);

        // R4 R5: quarter packing, big order
        do_reset(4, 1'b1);
        step(1'b1, 36'hF_FFFF_FE01, 1'b1);
        step(1'b1, 36'h0_0000_0002, 1'b1);
        chk(out_valid == 1'b0, "R5 no release when partial", {35'd0, out_valid}, 36'd0);
        step(1'b0, 36'h0, 1'b1);
        step(1'b1, 36'hA_AAAA_AA03, 1'b1);
        step(1'b1, 36'h0_0000_0004, 1'b1);
        step(1'b0, 36'h0, 1'b1);
        chk(last_out == ((36'd1 << 27) | (36'd2 << 18) | (36'd3 << 9) | 36'd4),
            "R4 R5 packed big", last_out, (36'd1 << 27) | (36'd2 << 18) | (36'd3 << 9) | 36'd4);

        // R7: partial word dropped on reset
        do_reset(4, 1'b0);
        step(1'b1, 36'h0_0000_0111, 1'b1);
        step(1'b1, 36'h0_0000_0122, 1'b1);
        do_reset(4, 1'b0);
        step(1'b1, 36'd5, 1'b1);
        step(1'b1, 36'd6, 1'b1);
        step(1'b1, 36'd7, 1'b1);
        step(1'b1, 36'd8, 1'b1);
        step(1'b0, 36'h0, 1'b1);
        chk(last_out == ((36'd8 << 27) | (36'd7 << 18) | (36'd6 << 9) | 36'd5),
            "R7 partial discarded", last_out, (36'd8 << 27) | (36'd7 << 18) | (36'd6 << 9) | 36'd5);
        chk(beats == 1, "R7 single word after reset", 36'(beats), 36'd1);

        // R8 R9: pass-through streams one word per cycle
        do_reset(0, 1'b0);
        for (int i = 0; i < 12; i++) begin
            w = {$urandom(), $urandom()};
            step(1'b1, w, 1'b1);
            chk(in_ready == 1'b1, "R8 in_ready held", {35'd0, in_ready}, 36'd1);
            if (i > 0) chk(out_valid == 1'b1, "R9 one-cycle latency", {35'd0, out_valid}, 36'd1);
        end
        drain();

        // random traffic over every pairing, both orders, one illegal code (R2)
        for (int m = 0; m < 6; m++) begin
            for (int b = 0; b < 2; b++) begin
                do_reset((m == 5) ? 6 : m, b[0]);
                for (int i = 0; i < 150; i++) begin
                    w = {$urandom(), $urandom()};
                    step(($urandom() % 4) != 0, w, ($urandom() % 10) < 7);
                end
                drain();
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 36'd0, 36'd1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule